// File: doc/BRIEF.md
# Modem Line Status Register

This block holds the modem status register of a 16550-style serial port. It samples four modem input lines (clear-to-send, data-set-ready, ring indicator and carrier detect) through a synchronizer. It remembers every change on them in sticky change flags. It raises a modem-status interrupt request while any flag is set and the host has enabled that interrupt. The host reads the register with a one-cycle read strobe. The read data is valid in the strobe cycle, and the change flags clear at the clock edge that ends the read.

The modem control register value comes in as an input. When its loopback bit is set, the register shows the modem control outputs in place of the external lines. The tracked levels and change flags are then held.

Top module: `mstat_reg`

## Requirements
- R1: The read data carries the current line levels in the upper nibble: bit 7 carrier detect, bit 6 ring indicator, bit 5 data-set-ready, bit 4 clear-to-send. A pin change shows there on the third rising clock edge after it is applied.
- R2: Bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) set when the line changes in either direction. They set on the same edge that updates the level.
- R3: Bit 2 sets when the ring indicator falls from 1 to 0.
- R4: A rising ring indicator leaves bit 2 clear.
- R5: Outside loopback, a read returns the flags and then clears bits 3:0 at the clock edge that ends the strobe cycle.
- R6: A change flag that sets on the same edge as a read clear stays set.
- R7: The interrupt request is high exactly when the enable input is high and any of bits 3:0 is set.
- R8: With MCR bit 4 (loopback) set, the upper nibble reads as follows: MCR bit 3 on bit 7, MCR bit 2 on bit 6, MCR bit 0 on bit 5, MCR bit 1 on bit 4. The low nibble reads as 0.
- R9: In loopback, pin changes update neither levels nor flags, and reads clear nothing. On leaving loopback, any difference between the held levels and the pins is reported as change flags.
- R10: After reset, the register reads 0xB0 and the interrupt request is low.
- R11: A set change flag stays set until a read outside loopback clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| ri_i | input | 1 | Ring indicator line, asynchronous |
| dcd_i | input | 1 | Carrier detect line, asynchronous |
| mcr_i | input | 5 | Modem control register value; bit 4 is loopback |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| rd_stb_i | input | 1 | One-cycle register read strobe |
| rd_data_o | output | 8 | Register read data |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that the read strobe and the control inputs are synchronous to the clock. They also assume that the modem lines are the only asynchronous inputs. The bench drives every input on the falling edge and samples on the falling edge, so each input is stable around each rising edge. A read strobe lasts one cycle. Pin changes are spaced at least three cycles apart, except in the directed case that lines up a flag setting with a read.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mline_t;

    typedef struct packed {
        logic d_dcd;
        logic fall_ri;
        logic d_dsr;
        logic d_cts;
    } mdelta_t;

    localparam int MCR_W     = 5;
    localparam int LOOP_BIT  = 4;
    localparam int OUT2_BIT  = 3;
    localparam int OUT1_BIT  = 2;
    localparam int RTS_BIT   = 1;
    localparam int DTR_BIT   = 0;

    localparam mline_t LINES_IDLE = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};

    function automatic mline_t loop_map(input logic [MCR_W-1:0] mcr);
        mline_t m;
        m.dcd = mcr[OUT2_BIT];
        m.ri  = mcr[OUT1_BIT];
        m.dsr = mcr[DTR_BIT];
        m.cts = mcr[RTS_BIT];
        return m;
    endfunction

    function automatic mdelta_t edge_flags(input mline_t prev, input mline_t now);
        mdelta_t d;
        d.d_dcd   = prev.dcd ^ now.dcd;
        d.fall_ri = prev.ri & ~now.ri;
        d.d_dsr   = prev.dsr ^ now.dsr;
        d.d_cts   = prev.cts ^ now.cts;
        return d;
    endfunction

endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= RST_VAL;
        else     chain_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[s] <= RST_VAL;
            else     chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mstat_track.sv
module mstat_track
    import mstat_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    upd_i,
    input  logic    clr_i,
    input  mline_t  smp_i,
    output mline_t  lvl_o,
    output mdelta_t delta_o
);
    mline_t  lvl_q;
    mdelta_t delta_q;
    mdelta_t set_w;

    always_comb begin
        set_w = '0;
        if (upd_i) set_w = edge_flags(lvl_q, smp_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= LINES_IDLE;
            delta_q <= '0;
        end else begin
            if (upd_i) lvl_q <= smp_i;
            delta_q <= (clr_i ? mdelta_t'('0) : delta_q) | set_w;
        end
    end

    assign lvl_o   = lvl_q;
    assign delta_o = delta_q;

    // R3
    a_r3_fall_sets: assert property (@(posedge clk) disable iff (rst)
        (upd_i && lvl_q.ri && !smp_i.ri) |=> delta_q.fall_ri);
    // R4
    a_r4_rise_quiet: assert property (@(posedge clk) disable iff (rst)
        (upd_i && !lvl_q.ri && smp_i.ri && !delta_q.fall_ri) |=> !delta_q.fall_ri);
    // R5
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_i && (!upd_i || smp_i == lvl_q)) |=> delta_q == 4'b0);
    // R6
    a_r6_keep_on_read: assert property (@(posedge clk) disable iff (rst)
        (clr_i && upd_i && (lvl_q.cts != smp_i.cts)) |=> delta_q.d_cts);
    // R9
    a_r9_loop_hold: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(lvl_q));
    // R11
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
endmodule

// File: rtl/mstat_irq.sv
module mstat_irq
    import mstat_pkg::*;
(
    input  logic    en_i,
    input  mdelta_t delta_i,
    output logic    irq_o
);
    assign irq_o = en_i & (|delta_i);

    // R7
    always_comb begin
        a_r7_gated: assert (!irq_o || en_i);
    end
endmodule

// File: rtl/mstat_reg.sv
module mstat_reg
    import mstat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cts_i,
    input  logic             dsr_i,
    input  logic             ri_i,
    input  logic             dcd_i,
    input  logic [MCR_W-1:0] mcr_i,
    input  logic             msi_en_i,
    input  logic             rd_stb_i,
    output logic [7:0]       rd_data_o,
    output logic             irq_o
);
    logic    loop_w;
    logic    clr_w;
    mline_t  pins_w;
    mline_t  smp_w;
    mline_t  lvl_w;
    mdelta_t delta_w;

    assign loop_w = mcr_i[LOOP_BIT];
    assign clr_w  = rd_stb_i & ~loop_w;
    assign pins_w = '{dcd: dcd_i, ri: ri_i, dsr: dsr_i, cts: cts_i};

    mstat_sync #(
        .WIDTH  ($bits(mline_t)),
        .STAGES (SYNC_STAGES),
        .RST_VAL(LINES_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i(pins_w),
        .q_o(smp_w)
    );

    mstat_track u_track (
        .clk    (clk),
        .rst    (rst),
        .upd_i  (~loop_w),
        .clr_i  (clr_w),
        .smp_i  (smp_w),
        .lvl_o  (lvl_w),
        .delta_o(delta_w)
    );

    mstat_irq u_irq (
        .en_i   (msi_en_i),
        .delta_i(delta_w),
        .irq_o  (irq_o)
    );

    always_comb begin
        if (loop_w) rd_data_o = {loop_map(mcr_i), 4'b0000};
        else        rd_data_o = {lvl_w, delta_w};
    end

    // R11: a pending request survives until a clearing read or a disable
    a_r11_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !clr_w) |=> (irq_o || !msi_en_i));
    // R10
    a_r10_reset_val: assert property (@(posedge clk)
        rst |=> (rd_data_o == 8'hB0 || loop_w));
endmodule

// File: tb/tb_mstat_reg.sv
module tb_mstat_reg;
    logic       clk = 1'b0;
    logic       rst;
    logic       cts_i, dsr_i, ri_i, dcd_i;
    logic [4:0] mcr_i;
    logic       msi_en_i, rd_stb_i;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    mstat_reg dut (
        .clk(clk), .rst(rst),
        .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i), .dcd_i(dcd_i),
        .mcr_i(mcr_i), .msi_en_i(msi_en_i), .rd_stb_i(rd_stb_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    // fields: pins{dcd,ri,dsr,cts}[14:11], en[10], rd[9], data[8:1], irq[0]
    localparam logic [14:0] VEC [10] = '{
        {4'hB, 1'b1, 1'b0, 8'hB0, 1'b0},  // R1 idle
        {4'hA, 1'b1, 1'b0, 8'hA1, 1'b1},  // R2 cts fall, R7
        {4'hA, 1'b1, 1'b1, 8'hA1, 1'b1},  // R11 held, R5 read
        {4'hA, 1'b1, 1'b0, 8'hA0, 1'b0},  // R5 cleared
        {4'hE, 1'b1, 1'b0, 8'hE0, 1'b0},  // R4 ri rise
        {4'hA, 1'b1, 1'b1, 8'hA4, 1'b1},  // R3 ri fall
        {4'h2, 1'b0, 1'b0, 8'h28, 1'b0},  // R2 dcd fall, R7 disabled
        {4'h3, 1'b1, 1'b1, 8'h39, 1'b1},  // R11 sticky plus cts rise
        {4'h1, 1'b1, 1'b1, 8'h12, 1'b1},  // R2 dsr fall
        {4'h1, 1'b1, 1'b0, 8'h10, 1'b0}   // R5 cleared
    };

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pins(logic [3:0] p);
        {dcd_i, ri_i, dsr_i, cts_i} = p;
    endtask

    task automatic chk(string req, logic [7:0] exp_d, logic exp_i);
        n_cmp++;
        if (rd_data_o !== exp_d || irq_o !== exp_i) begin
            n_bad++;
            $display("FAIL %s: data=%02h irq=%b expected data=%02h irq=%b",
                     req, rd_data_o, irq_o, exp_d, exp_i);
        end
    endtask

    task automatic rd_pulse();
        rd_stb_i = 1'b1;
        step(1);
        rd_stb_i = 1'b0;
    endtask

    initial begin
        rst = 1'b1; mcr_i = 5'h00; msi_en_i = 1'b1; rd_stb_i = 1'b0;
        pins(4'hB);
        step(3);
        rst = 1'b0;
        chk("R10 reset", 8'hB0, 1'b0);

        for (int i = 0; i < 10; i++) begin
            pins(VEC[i][14:11]);
            msi_en_i = VEC[i][10];
            step(3);
            chk($sformatf("R1/R2/R3/R4/R5/R7 vector %0d", i), VEC[i][8:1], VEC[i][0]);
            if (VEC[i][9]) rd_pulse();
        end

        // R6: flag sets on the edge that ends a read
        pins(4'h0);
        step(2);
        rd_stb_i = 1'b1;
        chk("R6 read value before event", 8'h10, 1'b0);
        step(1);
        rd_stb_i = 1'b0;
        chk("R6 event kept", 8'h01, 1'b1);
        rd_pulse();
        chk("R5 cleared after R6", 8'h00, 1'b0);

        // R8 loopback mapping
        mcr_i = 5'h1F; step(1);
        chk("R8 all on", 8'hF0, 1'b0);
        mcr_i = 5'h19; step(1);
        chk("R8 out2 dtr", 8'hA0, 1'b0);
        mcr_i = 5'h16; step(1);
        chk("R8 out1 rts", 8'h50, 1'b0);

        // R9: set a flag, enter loopback, read, toggle pins, leave
        mcr_i = 5'h00;
        pins(4'h8);
        step(3);
        chk("R2 dcd rise", 8'h88, 1'b1);
        mcr_i = 5'h16; step(1);
        chk("R9 loop view", 8'h50, 1'b1);
        rd_pulse();
        pins(4'hE);
        step(4);
        chk("R9 loop ignores pins and read", 8'h50, 1'b1);
        mcr_i = 5'h00;
        step(3);
        chk("R9 exit reports changes", 8'hEA, 1'b1);
        rd_pulse();
        chk("R5 final clear", 8'hE0, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule